// File: doc/BRIEF.md
# Multi-Register Load Sequencer

This block runs loads that fill several general-purpose registers from consecutive storage. The block is given a command once, while it is idle. It then issues a series of memory reads, one at a time, over a valid/ready request channel. It turns every response into one register-file write in the cycle that response arrives. Two operations are supported.

The first is a word-multiple load. It starts at a chosen register number and stops after register 31. It reads one 32-bit word per register, and the address rises by four each time.

The second is a quadword load. It fills an even/odd register pair from a 16-byte location using two doubleword reads. In little-endian mode it swaps which register gets which half and reverses the bytes of each half.

The block computes the starting address itself. It adds a sign-extended displacement to a base, and the base is zero when the base register number is 0. When the last write has been made, the block pulses a completion signal. A quadword command that names an odd register is rejected with an illegal-form flag, and no memory traffic is made for it.

Top module: `mreg_load_seq`

## Requirements
- R1: For a word-multiple load, the first request address is base + sign-extended 16-bit `cmd_disp`. The base is 0 when `cmd_ra_idx` is 0 and `cmd_ra_val` otherwise, and the sum wraps modulo 2^AW.
- R2: A word-multiple load starting at register `cmd_rt` writes registers `cmd_rt`, `cmd_rt`+1, … 31 in that order, one write per beat, for exactly 32−`cmd_rt` beats. A start at 31 makes exactly one beat.
- R3: Each word-multiple request has `mem_req_dword`=0 (a 4-byte read), and each request address is 4 above the one before it.
- R4: A word-multiple write carries `mem_rsp_data[31:0]` in `wb_data[31:0]` with `wb_data[63:32]`=0, whatever the upper response bits hold.
- R5: A quadword load (`cmd_quad`=1) issues exactly two requests with `mem_req_dword`=1. The first goes to base + sign-extension of {`cmd_disp[11:0]`, 4'b0000}, and `cmd_disp[15:12]` is ignored. The second goes to that address + 8.
- R6: In big-endian mode (`cmd_le`=0), the first response is written unchanged to register `cmd_rt` and the second to `cmd_rt`+1.
- R7: In little-endian mode (`cmd_le`=1), the first response is written to `cmd_rt`+1 and the second to `cmd_rt`. Each is byte-reversed: byte k moves to byte 7−k.
- R8: A quadword command with an odd `cmd_rt` issues no request and no write. In the cycle after it is accepted, `done` and `illegal` are both high for one cycle.
- R9: At most one request is outstanding. No new request is raised before the response to the previous one. A request with `mem_req_ready` low stays valid with the same address.
- R10: A write happens only in a cycle where a response is awaited and `mem_rsp_valid` is high. A response strobe while no read is pending produces no write.
- R11: After reset the block is idle: `cmd_ready`=1 and no request, write or `done`. `cmd_ready` is high only when idle, and `cmd_start` while busy is ignored.
- R12: `done` is high for exactly one cycle, the cycle after the final write. In the cycle after that, `cmd_ready` is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Start strobe, taken only when `cmd_ready` is high |
| cmd_ready | output | 1 | High while idle |
| cmd_quad | input | 1 | 0 selects the word-multiple load, 1 the quadword load |
| cmd_le | input | 1 | Little-endian mode for the quadword load |
| cmd_rt | input | IDX_W (5) | First target register number |
| cmd_ra_idx | input | IDX_W (5) | Base register number; 0 means a zero base |
| cmd_ra_val | input | AW (32) | Content of the base register |
| cmd_disp | input | DISP_W (16) | Displacement field |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | AW (32) | Read byte address |
| mem_req_dword | output | 1 | 1 for an 8-byte read, 0 for a 4-byte read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | XLEN (64) | Read data; the lowest-addressed byte is most significant; a 4-byte read is right-justified |
| wb_valid | output | 1 | Register write strobe |
| wb_idx | output | IDX_W (5) | Register number written |
| wb_data | output | XLEN (64) | Register write data |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Set with `done` when a quadword command named an odd register |

## Verification
The bench builds the block with its default parameters: a 32-bit address, 64-bit registers, 32 registers, a 16-bit displacement and a 12-bit quadword field. With 32 registers, runs from the single beat at register 31 up to a twelve-beat run are reached. A negative displacement from a zero base wraps the address to the top of the 32-bit space. The 12-bit field sits inside the 16-bit displacement, so upper displacement bits can be set to show that the quadword path ignores them. The memory model can hold off `mem_req_ready` and delay responses by several cycles. This exercises the hold and single-outstanding rules and both quadword orderings under back-pressure.

// File: rtl/mrl_pkg.sv
package mrl_pkg;

   localparam int BYTE_W = 8;
   localparam int WORD_W = 32;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2,
      ST_DONE  = 2'd3
   } mrl_state_e;

endpackage

// File: rtl/mrl_addr.sv
module mrl_addr #(
   parameter int AW          = 32,
   parameter int DISP_W      = 16,
   parameter int QFLD_W      = 12,
   parameter int WORD_BYTES  = 4,
   parameter int DW_BYTES    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   input  logic              quad_cmd,
   input  logic              quad_q,
   input  logic              base_zero,
   input  logic [AW-1:0]     base_val,
   input  logic [DISP_W-1:0] disp,
   output logic [AW-1:0]     addr
);

   localparam int QSHIFT = DISP_W - QFLD_W;
   localparam int EXT_W  = AW - DISP_W;

   initial begin : elab_chk
      assert (QFLD_W < DISP_W) else $error("mrl_addr: QFLD_W must be below DISP_W");
      assert (AW > DISP_W)     else $error("mrl_addr: AW must exceed DISP_W");
   end

   logic [AW-1:0]     base;
   logic [AW-1:0]     word_off;
   logic [DISP_W-1:0] quad_fld;
   logic [AW-1:0]     quad_off;
   logic [AW-1:0]     first_addr;
   logic [AW-1:0]     incr;
   logic [AW-1:0]     addr_q;

   always_comb begin
      base       = base_zero ? '0 : base_val;
      word_off   = {{EXT_W{disp[DISP_W-1]}}, disp};
      quad_fld   = {disp[QFLD_W-1:0], {QSHIFT{1'b0}}};
      quad_off   = {{EXT_W{quad_fld[DISP_W-1]}}, quad_fld};
      first_addr = base + (quad_cmd ? quad_off : word_off);
      incr       = quad_q ? AW'(DW_BYTES) : AW'(WORD_BYTES);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (load) begin
         addr_q <= first_addr;
      end else if (step) begin
         addr_q <= addr_q + incr;
      end
   end

   assign addr = addr_q;

   p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !step) |=> $stable(addr));

endmodule

// File: rtl/mrl_fmt.sv
module mrl_fmt #(
   parameter int XLEN   = 64,
   parameter int WORD_W = 32
) (
   input  logic [XLEN-1:0] rsp_data,
   input  logic            quad,
   input  logic            le,
   output logic [XLEN-1:0] wb_data
);

   localparam int NBYTES = XLEN / 8;
   localparam int PAD_W  = XLEN - WORD_W;

   initial begin : elab_chk
      assert (XLEN % 8 == 0)   else $error("mrl_fmt: XLEN must be whole bytes");
      assert (XLEN > WORD_W)   else $error("mrl_fmt: XLEN must exceed WORD_W");
   end

   logic [XLEN-1:0] swapped;
   logic [XLEN-1:0] word_ext;

   for (genvar gi = 0; gi < NBYTES; gi++) begin : g_lane
      assign swapped[8*gi +: 8] = rsp_data[XLEN-8-8*gi +: 8];
   end

   assign word_ext = {{PAD_W{1'b0}}, rsp_data[WORD_W-1:0]};

   always_comb begin
      if (!quad) begin
         wb_data = word_ext;
      end else if (le) begin
         wb_data = swapped;
      end else begin
         wb_data = rsp_data;
      end
   end

endmodule

// File: rtl/mrl_ctrl.sv
module mrl_ctrl
   import mrl_pkg::*;
#(
   parameter  int NREG  = 32,
   localparam int IDX_W = $clog2(NREG)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_start,
   input  logic             cmd_quad,
   input  logic             cmd_le,
   input  logic [IDX_W-1:0] cmd_rt,
   input  logic             req_ready,
   input  logic             rsp_valid,
   output logic             cmd_ready,
   output logic             req_valid,
   output logic             addr_load,
   output logic             addr_step,
   output logic             wb_valid,
   output logic [IDX_W-1:0] wb_idx,
   output logic             quad_q,
   output logic             le_q,
   output logic             done,
   output logic             illegal
);

   initial begin : elab_chk
      assert (NREG >= 2) else $error("mrl_ctrl: NREG must be at least 2");
   end

   mrl_state_e       state_q, state_d;
   logic [IDX_W-1:0] cur_q;
   logic [IDX_W-1:0] rt_q;
   logic             beat_q;
   logic             ill_q;
   logic             accept;
   logic             bad_form;
   logic             word_last;
   logic             last_beat;
   logic             rsp_take;

   assign accept   = (state_q == ST_IDLE) && cmd_start;
   assign bad_form = cmd_quad && cmd_rt[0];
   assign rsp_take = (state_q == ST_WAIT) && rsp_valid;

   if ((1 << IDX_W) == NREG) begin : g_last_pow2
      assign word_last = &cur_q;
   end else begin : g_last_cmp
      assign word_last = (cur_q == IDX_W'(NREG - 1));
   end

   assign last_beat = quad_q ? beat_q : word_last;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:  if (cmd_start) state_d = bad_form ? ST_DONE : ST_ISSUE;
         ST_ISSUE: if (req_ready) state_d = ST_WAIT;
         ST_WAIT:  if (rsp_valid) state_d = last_beat ? ST_DONE : ST_ISSUE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cur_q   <= '0;
         rt_q    <= '0;
         beat_q  <= 1'b0;
         quad_q  <= 1'b0;
         le_q    <= 1'b0;
         ill_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            cur_q  <= cmd_rt;
            rt_q   <= cmd_rt;
            beat_q <= 1'b0;
            quad_q <= cmd_quad;
            le_q   <= cmd_le;
            ill_q  <= bad_form;
         end else if (rsp_take && !last_beat) begin
            cur_q  <= cur_q + 1'b1;
            beat_q <= 1'b1;
         end
      end
   end

   assign cmd_ready = (state_q == ST_IDLE);
   assign req_valid = (state_q == ST_ISSUE);
   assign addr_load = accept && !bad_form;
   assign addr_step = rsp_take && !last_beat;
   assign wb_valid  = rsp_take;
   assign wb_idx    = quad_q ? {rt_q[IDX_W-1:1], beat_q ^ le_q} : cur_q;
   assign done      = (state_q == ST_DONE);
   assign illegal   = (state_q == ST_DONE) && ill_q;

   p_bad_form_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_ready && cmd_start && cmd_quad && cmd_rt[0]) |=> (done && illegal));

   p_last_reg_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && !quad_q && (wb_idx == IDX_W'(NREG - 1))) |=> done);

   p_ready_after_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (cmd_ready && !done));

   p_busy_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_ready && !done && cmd_start) |=> !cmd_ready);

endmodule

// File: rtl/mreg_load_seq.sv
module mreg_load_seq
   import mrl_pkg::*;
#(
   parameter  int AW     = 32,
   parameter  int XLEN   = 64,
   parameter  int NREG   = 32,
   parameter  int DISP_W = 16,
   parameter  int QFLD_W = 12,
   localparam int IDX_W  = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_start,
   output logic              cmd_ready,
   input  logic              cmd_quad,
   input  logic              cmd_le,
   input  logic [IDX_W-1:0]  cmd_rt,
   input  logic [IDX_W-1:0]  cmd_ra_idx,
   input  logic [AW-1:0]     cmd_ra_val,
   input  logic [DISP_W-1:0] cmd_disp,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [AW-1:0]     mem_req_addr,
   output logic              mem_req_dword,
   input  logic              mem_rsp_valid,
   input  logic [XLEN-1:0]   mem_rsp_data,
   output logic              wb_valid,
   output logic [IDX_W-1:0]  wb_idx,
   output logic [XLEN-1:0]   wb_data,
   output logic              done,
   output logic              illegal
);

   localparam int WORD_BYTES = WORD_W / BYTE_W;
   localparam int DW_BYTES   = XLEN / BYTE_W;

   initial begin : elab_chk
      assert (XLEN == 2 * WORD_W) else $error("mreg_load_seq: XLEN must be two words");
   end

   logic addr_load;
   logic addr_step;
   logic quad_q;
   logic le_q;
   logic base_zero;

   assign base_zero = (cmd_ra_idx == '0);

   mrl_ctrl #(.NREG(NREG)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_start (cmd_start),
      .cmd_quad  (cmd_quad),
      .cmd_le    (cmd_le),
      .cmd_rt    (cmd_rt),
      .req_ready (mem_req_ready),
      .rsp_valid (mem_rsp_valid),
      .cmd_ready (cmd_ready),
      .req_valid (mem_req_valid),
      .addr_load (addr_load),
      .addr_step (addr_step),
      .wb_valid  (wb_valid),
      .wb_idx    (wb_idx),
      .quad_q    (quad_q),
      .le_q      (le_q),
      .done      (done),
      .illegal   (illegal)
   );

   mrl_addr #(
      .AW         (AW),
      .DISP_W     (DISP_W),
      .QFLD_W     (QFLD_W),
      .WORD_BYTES (WORD_BYTES),
      .DW_BYTES   (DW_BYTES)
   ) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (addr_load),
      .step      (addr_step),
      .quad_cmd  (cmd_quad),
      .quad_q    (quad_q),
      .base_zero (base_zero),
      .base_val  (cmd_ra_val),
      .disp      (cmd_disp),
      .addr      (mem_req_addr)
   );

   mrl_fmt #(.XLEN(XLEN), .WORD_W(WORD_W)) u_fmt (
      .rsp_data (mem_rsp_data),
      .quad     (quad_q),
      .le       (le_q),
      .wb_data  (wb_data)
   );

   assign mem_req_dword = quad_q;

   p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

   p_one_outstanding_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

   p_wb_needs_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> mem_rsp_valid);

   p_word_zext_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && !mem_req_dword) |-> (wb_data[XLEN-1:WORD_W] == '0));

   p_done_after_wb_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && !mem_req_valid) |=> (done || mem_req_valid || !cmd_ready));

endmodule

// File: tb/sim_mreg_load_seq.sv
module sim_mreg_load_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_start = 1'b0;
   logic        cmd_ready;
   logic        cmd_quad = 1'b0;
   logic        cmd_le = 1'b0;
   logic [4:0]  cmd_rt = '0;
   logic [4:0]  cmd_ra_idx = '0;
   logic [31:0] cmd_ra_val = '0;
   logic [15:0] cmd_disp = '0;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b0;
   logic [31:0] mem_req_addr;
   logic        mem_req_dword;
   logic        mem_rsp_valid = 1'b0;
   logic [63:0] mem_rsp_data = '0;
   logic        wb_valid;
   logic [4:0]  wb_idx;
   logic [63:0] wb_data;
   logic        done;
   logic        illegal;

   always #4 clk = ~clk;

   mreg_load_seq u0 (
      .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_ready(cmd_ready),
      .cmd_quad(cmd_quad), .cmd_le(cmd_le), .cmd_rt(cmd_rt), .cmd_ra_idx(cmd_ra_idx),
      .cmd_ra_val(cmd_ra_val), .cmd_disp(cmd_disp), .mem_req_valid(mem_req_valid),
      .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr), .mem_req_dword(mem_req_dword),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .wb_valid(wb_valid),
      .wb_idx(wb_idx), .wb_data(wb_data), .done(done), .illegal(illegal)
   );

   int n_chk = 0;
   int n_err = 0;

   // memory model settings and state
   int          lat = 1;
   bit          stall = 1'b0;
   bit          spur = 1'b0;
   bit          pend = 1'b0;
   int          pcnt = 0;
   logic [31:0] paddr = '0;
   bit          pdw = 1'b0;
   int          cyc = 0;
   int          hold_err = 0;
   int          ovl_err = 0;
   bit          prev_wait = 1'b0;
   logic [31:0] prev_addr = '0;

   // logs
   logic [31:0] lg_addr [0:63];
   logic        lg_dw [0:63];
   logic [4:0]  lg_widx [0:63];
   logic [63:0] lg_wdata [0:63];
   int          lg_req_n = 0;
   int          lg_wb_n = 0;
   int          lg_wcyc = 0;
   int          lg_done_n = 0;
   int          lg_done_cyc = 0;
   logic        lg_ill = 1'b0;

   function automatic logic [31:0] wfun(input logic [31:0] a);
      return {a[15:0], a[31:16]} ^ 32'h5AC3_96E1;
   endfunction

   function automatic logic [63:0] dfun(input logic [31:0] a);
      return {wfun(a), wfun(a + 32'd4)};
   endfunction

   function automatic logic [63:0] rev64(input logic [63:0] d);
      logic [63:0] r;
      for (int i = 0; i < 8; i++) r[8*i +: 8] = d[56-8*i +: 8];
      return r;
   endfunction

   task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // memory model and monitor: drive just after falling edge, sample 1 ns later
   always begin
      @(negedge clk);
      cyc++;
      mem_rsp_valid = 1'b0;
      if (spur) begin
         mem_rsp_valid = 1'b1;
         mem_rsp_data  = 64'hFFFF_0000_FFFF_0000;
      end
      if (pend) begin
         pcnt--;
         if (pcnt == 0) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = pdw ? dfun(paddr) : {~paddr, wfun(paddr)};
            pend = 1'b0;
         end
      end
      mem_req_ready = stall ? ((cyc % 3) == 2) : 1'b1;
      #1;
      if (prev_wait && !(mem_req_valid && mem_req_addr == prev_addr)) hold_err++;
      if (mem_req_valid && pend) ovl_err++;
      prev_wait = mem_req_valid && !mem_req_ready;
      prev_addr = mem_req_addr;
      if (mem_req_valid && mem_req_ready) begin
         if (lg_req_n < 64) begin
            lg_addr[lg_req_n] = mem_req_addr;
            lg_dw[lg_req_n]   = mem_req_dword;
         end
         lg_req_n++;
         pend  = 1'b1;
         pcnt  = lat;
         paddr = mem_req_addr;
         pdw   = mem_req_dword;
      end
      if (wb_valid) begin
         if (lg_wb_n < 64) begin
            lg_widx[lg_wb_n]  = wb_idx;
            lg_wdata[lg_wb_n] = wb_data;
         end
         lg_wb_n++;
         lg_wcyc = cyc;
      end
      if (done) begin
         lg_done_n++;
         lg_done_cyc = cyc;
         lg_ill = illegal;
      end
   end

   task automatic clear_logs;
      lg_req_n = 0; lg_wb_n = 0; lg_done_n = 0; lg_ill = 1'b0;
   endtask

   task automatic start_cmd(input bit q, input bit le, input logic [4:0] rt,
                            input logic [4:0] ra, input logic [31:0] rv, input logic [15:0] d);
      @(negedge clk);
      clear_logs();
      cmd_quad = q; cmd_le = le; cmd_rt = rt; cmd_ra_idx = ra; cmd_ra_val = rv; cmd_disp = d;
      cmd_start = 1'b1;
      @(negedge clk);
      cmd_start = 1'b0;
   endtask

   task automatic wait_done;
      int t = 0;
      while (lg_done_n == 0 && t < 3000) begin
         @(negedge clk);
         t++;
      end
      #2;
      chk(lg_done_n == 1, "R12 single done pulse", 64'(lg_done_n), 64'd1);
      @(negedge clk);
      #2;
      chk(cmd_ready == 1'b1, "R12 ready after done", 64'(cmd_ready), 64'd1);
   endtask

   task automatic verify_word(input logic [4:0] rt, input logic [31:0] ea);
      int n = 32 - int'(rt);
      chk(lg_req_n == n, "R2 request count", 64'(lg_req_n), 64'(n));
      chk(lg_wb_n == n, "R2 write count", 64'(lg_wb_n), 64'(n));
      chk(lg_addr[0] == ea, "R1 first address", 64'(lg_addr[0]), 64'(ea));
      for (int k = 0; k < n && k < lg_req_n && k < lg_wb_n; k++) begin
         logic [31:0] a = ea + 32'(4 * k);
         chk(lg_addr[k] == a, "R3 address step", 64'(lg_addr[k]), 64'(a));
         chk(lg_dw[k] == 1'b0, "R3 word size", 64'(lg_dw[k]), 64'd0);
         chk(lg_widx[k] == rt + 5'(k), "R2 register order", 64'(lg_widx[k]), 64'(rt + 5'(k)));
         chk(lg_wdata[k] == {32'h0, wfun(a)}, "R4 zero-extended word", lg_wdata[k], {32'h0, wfun(a)});
      end
      chk(lg_done_cyc == lg_wcyc + 1, "R12 done after last write", 64'(lg_done_cyc), 64'(lg_wcyc + 1));
      chk(lg_ill == 1'b0, "R8 no illegal on word load", 64'(lg_ill), 64'd0);
   endtask

   task automatic verify_quad(input logic [4:0] rt, input bit le, input logic [31:0] ea);
      logic [63:0] d0 = dfun(ea);
      logic [63:0] d1 = dfun(ea + 32'd8);
      chk(lg_req_n == 2, "R5 two requests", 64'(lg_req_n), 64'd2);
      chk(lg_wb_n == 2, "R5 two writes", 64'(lg_wb_n), 64'd2);
      chk(lg_addr[0] == ea, "R5 first address", 64'(lg_addr[0]), 64'(ea));
      chk(lg_addr[1] == ea + 32'd8, "R5 second address", 64'(lg_addr[1]), 64'(ea + 32'd8));
      chk(lg_dw[0] && lg_dw[1], "R5 doubleword size", 64'({lg_dw[0], lg_dw[1]}), 64'd3);
      if (!le) begin
         chk(lg_widx[0] == rt, "R6 even gets first", 64'(lg_widx[0]), 64'(rt));
         chk(lg_wdata[0] == d0, "R6 first data", lg_wdata[0], d0);
         chk(lg_widx[1] == rt + 5'd1, "R6 odd gets second", 64'(lg_widx[1]), 64'(rt + 5'd1));
         chk(lg_wdata[1] == d1, "R6 second data", lg_wdata[1], d1);
      end else begin
         chk(lg_widx[0] == rt + 5'd1, "R7 odd gets first", 64'(lg_widx[0]), 64'(rt + 5'd1));
         chk(lg_wdata[0] == rev64(d0), "R7 first reversed", lg_wdata[0], rev64(d0));
         chk(lg_widx[1] == rt, "R7 even gets second", 64'(lg_widx[1]), 64'(rt));
         chk(lg_wdata[1] == rev64(d1), "R7 second reversed", lg_wdata[1], rev64(d1));
      end
      chk(lg_done_cyc == lg_wcyc + 1, "R12 done after last write", 64'(lg_done_cyc), 64'(lg_wcyc + 1));
   endtask

   task automatic t_reset;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(cmd_ready == 1'b1, "R11 reset ready", 64'(cmd_ready), 64'd1);
      chk(mem_req_valid == 1'b0, "R11 reset no request", 64'(mem_req_valid), 64'd0);
      chk(wb_valid == 1'b0 && done == 1'b0, "R11 reset no write or done", 64'({wb_valid, done}), 64'd0);
   endtask

   task automatic t_word_basic;
      lat = 1; stall = 1'b0;
      start_cmd(1'b0, 1'b0, 5'd28, 5'd3, 32'h0000_1000, 16'hFFF8);
      wait_done();
      verify_word(5'd28, 32'h0000_0FF8);
   endtask

   task automatic t_word_single_wrap;
      lat = 2; stall = 1'b0;
      start_cmd(1'b0, 1'b0, 5'd31, 5'd0, 32'hDEAD_0000, 16'hFFFC);
      wait_done();
      verify_word(5'd31, 32'hFFFF_FFFC);
   endtask

   task automatic t_word_stalled;
      lat = 3; stall = 1'b1;
      start_cmd(1'b0, 1'b0, 5'd20, 5'd5, 32'h4000_0000, 16'h0100);
      wait_done();
      verify_word(5'd20, 32'h4000_0100);
   endtask

   task automatic t_quad_be;
      lat = 1; stall = 1'b1;
      start_cmd(1'b1, 1'b0, 5'd6, 5'd2, 32'h0000_2000, 16'hAFFF);
      wait_done();
      verify_quad(5'd6, 1'b0, 32'h0000_1FF0);
   endtask

   task automatic t_quad_le;
      lat = 2; stall = 1'b1;
      start_cmd(1'b1, 1'b1, 5'd10, 5'd0, 32'h1234_5678, 16'h0010);
      wait_done();
      verify_quad(5'd10, 1'b1, 32'h0000_0100);
   endtask

   task automatic t_quad_odd;
      lat = 1; stall = 1'b0;
      start_cmd(1'b1, 1'b0, 5'd7, 5'd2, 32'h0000_3000, 16'h0001);
      wait_done();
      chk(lg_req_n == 0, "R8 no request", 64'(lg_req_n), 64'd0);
      chk(lg_wb_n == 0, "R8 no write", 64'(lg_wb_n), 64'd0);
      chk(lg_ill == 1'b1, "R8 illegal with done", 64'(lg_ill), 64'd1);
   endtask

   task automatic t_busy_and_spurious;
      lat = 4; stall = 1'b0;
      @(negedge clk);
      clear_logs();
      @(posedge clk);
      spur = 1'b1;
      @(posedge clk);
      spur = 1'b0;
      @(negedge clk);
      #2;
      chk(lg_wb_n == 0, "R10 idle response ignored", 64'(lg_wb_n), 64'd0);
      start_cmd(1'b0, 1'b0, 5'd30, 5'd1, 32'h0000_8000, 16'h0040);
      @(negedge clk);
      #1;
      chk(cmd_ready == 1'b0, "R11 not ready while busy", 64'(cmd_ready), 64'd0);
      cmd_quad = 1'b1; cmd_rt = 5'd2; cmd_disp = 16'h0300;
      cmd_start = 1'b1;
      @(negedge clk);
      cmd_start = 1'b0;
      wait_done();
      verify_word(5'd30, 32'h0000_8040);
   endtask

   bit finished = 1'b0;

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_word_basic();
      t_word_single_wrap();
      t_word_stalled();
      t_quad_be();
      t_quad_le();
      t_quad_odd();
      t_busy_and_spurious();
      chk(hold_err == 0, "R9 request held while not ready", 64'(hold_err), 64'd0);
      chk(ovl_err == 0, "R9 one outstanding", 64'(ovl_err), 64'd0);
      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule